// File: doc/BRIEF.md
# Programmable Post-Divider Clock Tree

This block turns one VCO clock into two derived clocks: a pixel clock and a byte clock. The pixel clock comes from one wide programmable divider fed by the VCO. The byte clock comes from a chain. A 4-bit programmable divider feeds a fixed halving stage. A two-way selector then picks either that halved clock or the raw VCO. A fixed divide-by-four stage follows the selector. Three configuration fields set the tree up: the chain divider code, the pixel divider code and the selector bit. They are written through a small address/data write port. A save pulse copies the three fields into a shadow copy, and a restore pulse copies the shadow back. This lets a power-down sequence bring the same clock setup back later.

All logic runs on a fast sampling clock `clk`. The VCO arrives as the level `vco_in`. Each divider counts rising edges of its source level and produces a registered level. Divider code N gives a ratio of N+1. Code 0 passes the source straight through. A new code is held pending and takes effect only when the current output period ends.

The selector is a state machine with six states, in two mirrored halves. In `M_ON0` it forwards input 0. A select of 1 moves it to `M_DROP0`, which keeps forwarding until input 0 is seen low. It then moves to `M_HAND1`, where both gates are closed, and waits until input 1 is seen low. After that it moves to `M_ON1`, which forwards input 1. The return path runs the same way: `M_ON1` → `M_DROP1` → `M_HAND0` → `M_ON0`. In both directions a gate only opens or closes while its input is low.

Top module: `pdiv_clock_tree`

## Requirements
- R1: During reset both output clocks are low. After reset all three fields are zero, so the pixel clock follows the VCO (ratio 1) and the byte clock is the VCO divided by 4.
- R2: A write to address 0 loads data bits 3:0 as the chain divider code. Address 1 loads bits 7:0 as the pixel divider code. Address 2 loads bit 1 as the selector (1 = halved chain clock, 0 = raw VCO). Other data bits and address 3 have no effect.
- R3: A divider code N divides its source by N+1, and code 0 passes the source through unchanged.
- R4: For ratios of 2 or more, each output high phase lasts floor((N+1)/2) source periods. The remainder of the period is the low phase.
- R5: With selector 1 the byte clock period is 8·(A+1) VCO periods, where A is the chain code. With selector 0 it is 4 VCO periods. In both cases its high phase is half the period.
- R6: A code written during an output period does not change that period. The new ratio starts at the next rising edge of the output.
- R7: A selector change never shortens a high phase. Every rise and fall of the selector output follows the same edge of the input that is selected at that moment.
- R8: While the enable input is low, both output clocks are low from the next cycle. When enable returns, division resumes with the programmed codes.
- R9: A save pulse copies the three fields into a shadow copy, and a restore pulse loads them back. A restore in the same cycle as a write takes precedence over the write.
- R10: Each pixel clock rising edge comes one cycle after a rising edge of the registered VCO level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vco_in | input | 1 | VCO clock level, sampled on clk |
| en | input | 1 | Output enable; low holds both outputs low |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 2 | Field select: 0 chain code, 1 pixel code, 2 selector |
| wr_data | input | 8 | Write data |
| save_req | input | 1 | Copy fields into the shadow copy |
| restore_req | input | 1 | Load fields from the shadow copy |
| pix_clk | output | 1 | Pixel clock |
| byte_clk | output | 1 | Byte clock |

## Verification
The assertions watch every cycle for several rules. Outputs must go low after enable drops. The selector output may only change on a matching edge of the selected input, so no runt or truncated pulse gets out. Pixel and byte edges must line up with the edges of their sources. A restore must reproduce the shadow copy. Only the bench's scenarios can show that the measured periods and high phases match each code. The same holds for a code written mid-period taking effect one period late, for a full save/write/restore cycle bringing the old clock rates back, and for ignored address and data bits leaving the rates unchanged.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

    localparam int ANA_W   = 4;
    localparam int PIX_W   = 8;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int SEL_BIT = 1;

    localparam logic [ADDR_W-1:0] A_ANA = 2'd0;
    localparam logic [ADDR_W-1:0] A_PIX = 2'd1;
    localparam logic [ADDR_W-1:0] A_SEL = 2'd2;

    typedef struct packed {
        logic [ANA_W-1:0] ana;
        logic [PIX_W-1:0] pix;
        logic             sel;
    } cfg_t;

    typedef enum logic [2:0] {
        M_ON0,
        M_DROP0,
        M_HAND1,
        M_ON1,
        M_DROP1,
        M_HAND0
    } mux_state_e;

endpackage

// File: rtl/pdiv_ctrl.sv
module pdiv_ctrl
    import pdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              save_req,
    input  logic              restore_req,
    output cfg_t              cfg,
    output cfg_t              snap
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg  <= '0;
            snap <= '0;
        end else begin
            if (save_req) begin
                snap <= cfg;
            end
            if (restore_req) begin
                cfg <= snap;
            end else if (wr_en) begin
                case (wr_addr)
                    A_ANA:   cfg.ana <= wr_data[ANA_W-1:0];
                    A_PIX:   cfg.pix <= wr_data[PIX_W-1:0];
                    A_SEL:   cfg.sel <= wr_data[SEL_BIT];
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pdiv_stage.sv
module pdiv_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         src,
    input  logic [W-1:0] code,
    output logic         out
);

    logic         src_d;
    logic [W-1:0] cnt;
    logic [W-1:0] act;
    logic         tick;
    logic         last;
    logic [W-1:0] cnt_n;
    logic [W-1:0] act_n;
    logic [W:0]   half;

    always_comb begin
        tick  = src & ~src_d;
        last  = (cnt == act);
        act_n = (tick && last) ? code : act;
        cnt_n = cnt;
        if (tick) begin
            cnt_n = last ? '0 : cnt + W'(1);
        end
        half  = ({1'b0, act_n} + (W+1)'(1)) >> 1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            src_d <= 1'b0;
            cnt   <= code;
            act   <= code;
        end else begin
            src_d <= src;
            if (tick) begin
                cnt <= cnt_n;
                act <= act_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            out <= 1'b0;
        end else if (tick) begin
            out <= (act_n == '0) ? 1'b1 : ({1'b0, cnt_n} < half);
        end else if (act == '0) begin
            out <= src;
        end
    end

endmodule

// File: rtl/pdiv_glitchless_mux.sv
module pdiv_glitchless_mux
    import pdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic s0,
    input  logic s1,
    output logic out
);

    mux_state_e state, state_n;
    logic       gate0, gate1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= M_ON0;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            M_ON0:   if (sel)  state_n = M_DROP0;
            M_DROP0: if (!s0)  state_n = M_HAND1;
            M_HAND1: if (!s1)  state_n = M_ON1;
            M_ON1:   if (!sel) state_n = M_DROP1;
            M_DROP1: if (!s1)  state_n = M_HAND0;
            M_HAND0: if (!s0)  state_n = M_ON0;
            default:           state_n = M_ON0;
        endcase
    end

    always_comb begin
        gate0 = (state == M_ON0) || (state == M_DROP0);
        gate1 = (state == M_ON1) || (state == M_DROP1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out <= 1'b0;
        end else begin
            out <= (gate0 & s0) | (gate1 & s1);
        end
    end

endmodule

// File: rtl/pdiv_clock_tree.sv
module pdiv_clock_tree
    import pdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vco_in,
    input  logic              en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              save_req,
    input  logic              restore_req,
    output logic              pix_clk,
    output logic              byte_clk
);

    localparam int HALF_DIV = 2;
    localparam int BYTE_DIV = 4;
    localparam int HALF_W   = $clog2(HALF_DIV);
    localparam int BYTE_W   = $clog2(BYTE_DIV);

    cfg_t cfg_q;
    cfg_t snap_q;
    logic vco_q;
    logic ana_clk;
    logic half_clk;
    logic mux_clk;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vco_q <= 1'b0;
        end else begin
            vco_q <= vco_in;
        end
    end

    pdiv_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .save_req    (save_req),
        .restore_req (restore_req),
        .cfg         (cfg_q),
        .snap        (snap_q)
    );

    pdiv_stage #(.W(ANA_W)) u_ana (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .src   (vco_q),
        .code  (cfg_q.ana),
        .out   (ana_clk)
    );

    pdiv_stage #(.W(HALF_W)) u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .src   (ana_clk),
        .code  (HALF_W'(HALF_DIV - 1)),
        .out   (half_clk)
    );

    pdiv_glitchless_mux u_mux (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (cfg_q.sel),
        .s0    (vco_q),
        .s1    (half_clk),
        .out   (mux_clk)
    );

    pdiv_stage #(.W(BYTE_W)) u_byte (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .src   (mux_clk),
        .code  (BYTE_W'(BYTE_DIV - 1)),
        .out   (byte_clk)
    );

    pdiv_stage #(.W(PIX_W)) u_pix (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .src   (vco_q),
        .code  (cfg_q.pix),
        .out   (pix_clk)
    );

endmodule

// File: rtl/pdiv_clock_tree_chk.sv
module pdiv_clock_tree_chk
    import pdiv_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic restore_req,
    input logic vco_q,
    input logic half_clk,
    input logic mux_clk,
    input logic pix_clk,
    input logic byte_clk,
    input cfg_t cfg_q,
    input cfg_t snap_q
);

    // R8: disabled tree drives both outputs low
    p_low_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pix_clk && !byte_clk));

    // R7: selector output rises only with a rise of an input
    p_mux_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mux_clk) |-> ($past($rose(vco_q)) || $past($rose(half_clk))));

    // R7: selector output falls only with a fall of an input
    p_mux_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mux_clk) |-> ($past($fell(vco_q)) || $past($fell(half_clk))));

    // R10: pixel rising edges follow VCO rising edges
    p_pix_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_clk) |-> $past($rose(vco_q)));

    // R5: byte rising edges follow selector output rising edges
    p_byte_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_clk) |-> $past($rose(mux_clk)));

    // R9: restore reproduces the shadow copy
    p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req |=> (cfg_q == $past(snap_q)));

endmodule

bind pdiv_clock_tree pdiv_clock_tree_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .restore_req (restore_req),
    .vco_q       (vco_q),
    .half_clk    (half_clk),
    .mux_clk     (mux_clk),
    .pix_clk     (pix_clk),
    .byte_clk    (byte_clk),
    .cfg_q       (cfg_q),
    .snap_q      (snap_q)
);

// File: tb/pdiv_clock_tree_tb_top.sv
module pdiv_clock_tree_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vco_in = 1'b0;
    logic       en = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       save_req = 1'b0;
    logic       restore_req = 1'b0;
    logic       pix_clk;
    logic       byte_clk;

    int checks = 0;
    int errors = 0;
    int min_run = 1000000;
    int run_len = 0;
    bit armed = 1'b0;

    // pixel code, expected high samples, expected period (VCO period = 2 clk)
    localparam int NVEC = 6;
    localparam int VEC [NVEC][3] = '{
        '{0,   1,   2},
        '{1,   2,   4},
        '{2,   2,   6},
        '{6,   6,  14},
        '{255, 256, 512},
        '{4,   4,  10}
    };

    pdiv_clock_tree dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .vco_in      (vco_in),
        .en          (en),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .save_req    (save_req),
        .restore_req (restore_req),
        .pix_clk     (pix_clk),
        .byte_clk    (byte_clk)
    );

    always #5 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            vco_in = ~vco_in;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (byte_clk) begin
                run_len++;
            end else begin
                if (armed && run_len > 0 && run_len < min_run) min_run = run_len;
                run_len = 0;
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        summary();
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic sigv(input int which);
        return (which == 0) ? pix_clk : byte_clk;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic meas(input int which, output int hi, output int per);
        int lo;
        hi = 0; lo = 0;
        while (sigv(which) != 1'b0) @(negedge clk);
        while (sigv(which) != 1'b1) @(negedge clk);
        while (sigv(which) == 1'b1) begin hi++; @(negedge clk); end
        while (sigv(which) == 1'b0) begin lo++; @(negedge clk); end
        per = hi + lo;
    endtask

    task automatic meas2(input int which, output int hi, output int per);
        meas(which, hi, per);
        meas(which, hi, per);
    endtask

    initial begin
        int hi, per, lo;
        bit low_ok;

        repeat (5) @(negedge clk);
        chk("R1 pix low in reset", int'(pix_clk), 0);
        chk("R1 byte low in reset", int'(byte_clk), 0);
        rst_n = 1'b1;

        meas2(0, hi, per);
        chk("R1 pix period after reset", per, 2);
        meas2(1, hi, per);
        chk("R1 byte period after reset", per, 8);
        chk("R1 byte high after reset", hi, 4);

        // R3 R4: divider table
        for (int i = 0; i < NVEC; i++) begin
            wr(2'd1, 8'(VEC[i][0]));
            meas2(0, hi, per);
            chk("R3 pix period", per, VEC[i][2]);
            chk("R4 pix high", hi, VEC[i][1]);
        end

        // R2: address 3 ignored
        wr(2'd3, 8'hFF);
        meas2(0, hi, per);
        chk("R2 addr3 ignored, pix period", per, 10);

        // R5 R7: chain code 2 (upper bits ignored), selector to chain
        armed = 1'b1;
        wr(2'd0, 8'hF2);
        wr(2'd2, 8'h03);
        meas2(1, hi, per);
        chk("R5 byte period sel1", per, 48);
        chk("R5 byte high sel1", hi, 24);
        wr(2'd2, 8'h01);
        meas2(1, hi, per);
        chk("R2 sel bit0 ignored, byte period", per, 8);
        armed = 1'b0;
        chk("R7 no short byte high across switches", int'(min_run >= 4), 1);

        // R6: code written mid-period takes effect next period
        wr(2'd1, 8'd9);
        meas2(0, hi, per);
        while (pix_clk != 1'b0) @(negedge clk);
        while (pix_clk != 1'b1) @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'd1;
        hi = 1;
        @(negedge clk);
        wr_en = 1'b0;
        while (pix_clk == 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (pix_clk == 1'b0) begin lo++; @(negedge clk); end
        chk("R6 current period kept", hi + lo, 20);
        meas(0, hi, per);
        chk("R6 new ratio next period", per, 4);

        // R8: enable low
        en = 1'b0;
        @(negedge clk);
        low_ok = 1'b1;
        repeat (30) begin
            if (pix_clk || byte_clk) low_ok = 1'b0;
            @(negedge clk);
        end
        chk("R8 outputs low while disabled", int'(low_ok), 1);
        en = 1'b1;
        meas2(0, hi, per);
        chk("R8 pix resumes", per, 4);

        // R9: save / restore
        wr(2'd1, 8'd4);
        wr(2'd2, 8'h02);
        save_req = 1'b1; @(negedge clk); save_req = 1'b0;
        wr(2'd1, 8'd0);
        wr(2'd2, 8'h00);
        meas2(0, hi, per);
        chk("R9 pix changed after save", per, 2);
        restore_req = 1'b1; @(negedge clk); restore_req = 1'b0;
        meas2(0, hi, per);
        chk("R9 pix restored", per, 10);
        meas2(1, hi, per);
        chk("R9 byte restored", per, 48);
        restore_req = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'd7;
        @(negedge clk);
        restore_req = 1'b0; wr_en = 1'b0;
        meas2(0, hi, per);
        chk("R9 restore beats write", per, 10);

        summary();
        $finish;
    end

endmodule